// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers a set of interrupt request lines, each with its own programmable priority, and raises one interrupt request toward the processor. The request goes up only when the best pending line has a priority strictly above the current priority level. When two lines share the top priority, the line with the lower index wins. The index of the winner is its vector. That vector is captured at the moment the processor request rises and is held there until the request rises again.

Software takes an interrupt through a register handshake on a small bus. Reading the acknowledge register does three things: it returns the held vector as a word-aligned table offset, it saves the current priority in a hardware last-in first-out stack, and it raises the current priority to that of the acknowledged line. Writing any value to the end-of-interrupt register restores the most recently saved priority. The controller never searches for the line whose handler was interrupted. It only compares pending lines against the restored level. Handlers must clear their source before they signal end of interrupt.

Top module: `prio_intc`

## Requirements
- R1: After reset the processor request is low, the current priority is 0, every source priority is 0, and the acknowledge register reads 0.
- R2: The processor request is registered. One clock after any change to its inputs, it is high exactly when some asserted line has a priority strictly greater than the current priority. A line at or below the current priority never raises it.
- R3: Among asserted lines, the highest priority wins. On a tie, the lowest line index wins. The vector equals the winner's index.
- R4: The vector is loaded when the processor request rises and is held until the request next rises. A higher line arriving while the request is already high does not change it.
- R5: A read at address 1 (acknowledge) returns the vector in bits [IDX_W+1:2] with bits [1:0] at zero. On the clock edge that ends that read, the old current priority is pushed onto the stack, the current priority becomes the acknowledged line's priority, and the processor request goes low.
- R6: A write of any value to address 2 (end of interrupt) pops the stack into the current priority. A pop on an empty stack restores priority 0. The stack is 2**PRI_W entries deep.
- R7: After a pop, a line still asserted at or below the restored level causes no request. A line above the restored level raises the request one clock later.
- R8: Address 0 holds the current priority, which is readable and writable in bits [PRI_W-1:0]. Address 4+i holds the priority of line i, which is readable and writable. Address 2 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcReq | input | NUM_SRC | Interrupt request lines, active high |
| busWr | input | 1 | Register write strobe, one cycle per access |
| busRd | input | 1 | Register read strobe, one cycle per access |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | PRI_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the cycle of the read strobe |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with eight lines and 4-bit priorities. This gives a 16-deep stack, so the top priority 15 and the level-0 source that can never fire are both reachable. Eight lines are enough to hold several ties at one priority, which exercises the lowest-index rule at two levels. The priorities chosen also support a two-deep nesting with a held vector and a return to a level that still has a pending line.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  localparam int ADR_CUR  = 0;
  localparam int ADR_ACK  = 1;
  localparam int ADR_EOI  = 2;
  localparam int ADR_SRC0 = 4;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CUR  = 2'd1,
    RD_ACK  = 2'd2,
    RD_SRC  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrCur;
    logic   wrSrc;
    logic   ackRd;
    logic   eoiWr;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/prio_intc_ctrl.sv
module prio_intc_ctrl
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb,
  output logic [IDX_W-1:0]  srcIdx
);

  logic srcHit;
  logic rdOnly;

  always_comb begin
    srcHit = 1'b0;
    srcIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (busAddr == ADDR_W'(ADR_SRC0 + i)) begin
        srcHit = 1'b1;
        srcIdx = IDX_W'(i);
      end
    end
  end

  // A write wins if both strobes are raised together.
  assign rdOnly = busRd && !busWr;

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    stb.wrCur = busWr && (busAddr == ADDR_W'(ADR_CUR));
    stb.eoiWr = busWr && (busAddr == ADDR_W'(ADR_EOI));
    stb.wrSrc = busWr && srcHit;
    stb.ackRd = rdOnly && (busAddr == ADDR_W'(ADR_ACK));
    if (rdOnly) begin
      if (busAddr == ADDR_W'(ADR_CUR))      stb.rdSel = RD_CUR;
      else if (busAddr == ADDR_W'(ADR_ACK)) stb.rdSel = RD_ACK;
      else if (srcHit)                      stb.rdSel = RD_SRC;
    end
  end

endmodule

// File: rtl/prio_intc_lifo.sv
module prio_intc_lifo #(
  parameter int DEPTH = 16,
  parameter int W     = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] pushData,
  output logic [W-1:0] topData,
  output logic         empty,
  output logic         full
);

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));

  // An empty stack presents level 0 as its top.
  assign topData = empty ? '0 : mem[PTR_W'(cnt - 1'b1)];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (push && !full) begin
      cnt <= cnt + 1'b1;
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[PTR_W'(cnt)] <= pushData;
  end

endmodule

// File: rtl/prio_intc_dpath.sv
module prio_intc_dpath
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRI_W   = 4,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [IDX_W-1:0]   srcIdx,
  input  logic [PRI_W-1:0]   wrData,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [PRI_W-1:0]   popData,
  output logic [PRI_W-1:0]   curPri,
  output logic [IDX_W-1:0]   vecReg,
  output logic               irqOut,
  output logic [DATA_W-1:0]  rdData
);

  logic [PRI_W-1:0] srcPri [NUM_SRC];
  logic             bestValid;
  logic [PRI_W-1:0] bestPri;
  logic [IDX_W-1:0] bestIdx;
  logic             irqNext;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pri
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  srcPri[g] <= '0;
      else if (stb.wrSrc && srcIdx == IDX_W'(g))  srcPri[g] <= wrData;
    end
  end

  // Scan upward; replace only on a strictly higher level, so ties keep the lower index.
  always_comb begin
    bestValid = 1'b0;
    bestPri   = '0;
    bestIdx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcReq[i] && (!bestValid || srcPri[i] > bestPri)) begin
        bestValid = 1'b1;
        bestPri   = srcPri[i];
        bestIdx   = IDX_W'(i);
      end
    end
  end

  assign irqNext = bestValid && (bestPri > curPri);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPri <= '0;
    end else if (stb.ackRd) begin
      curPri <= srcPri[vecReg];
    end else if (stb.eoiWr) begin
      curPri <= popData;
    end else if (stb.wrCur) begin
      curPri <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      vecReg <= '0;
    end else if (stb.ackRd) begin
      irqOut <= 1'b0;
    end else begin
      irqOut <= irqNext;
      if (irqNext && !irqOut) vecReg <= bestIdx;
    end
  end

  always_comb begin
    case (stb.rdSel)
      RD_CUR:  rdData = DATA_W'(curPri);
      RD_ACK:  rdData = DATA_W'(vecReg) << 2;
      RD_SRC:  rdData = DATA_W'(srcPri[srcIdx]);
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRI_W   = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int DEPTH  = 1 << PRI_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [PRI_W-1:0]   busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut
);

  strobe_t          stb;
  logic [IDX_W-1:0] srcIdx;
  logic [PRI_W-1:0] curPri;
  logic [PRI_W-1:0] lifoTop;
  logic [IDX_W-1:0] vecReg;
  logic             lifoEmpty;
  logic             lifoFull;

  prio_intc_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .stb     (stb),
    .srcIdx  (srcIdx)
  );

  prio_intc_lifo #(.DEPTH(DEPTH), .W(PRI_W)) u_lifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (stb.ackRd),
    .pop      (stb.eoiWr),
    .pushData (curPri),
    .topData  (lifoTop),
    .empty    (lifoEmpty),
    .full     (lifoFull)
  );

  prio_intc_dpath #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W), .DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .srcIdx  (srcIdx),
    .wrData  (busWdata),
    .srcReq  (srcReq),
    .popData (lifoTop),
    .curPri  (curPri),
    .vecReg  (vecReg),
    .irqOut  (irqOut),
    .rdData  (busRdata)
  );

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int PRI_W = 4,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             irqOut,
  input logic             ackRd,
  input logic             eoiWr,
  input logic             wrCur,
  input logic             wrSrc,
  input logic [PRI_W-1:0] curPri,
  input logic [PRI_W-1:0] lifoTop,
  input logic [IDX_W-1:0] vecReg,
  input logic             lifoEmpty,
  input logic             lifoFull
);

  assert_vec_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && $past(irqOut)) |-> $stable(vecReg));

  assert_ack_drops_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    ackRd |=> !irqOut);

  assert_ack_pushes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ackRd && !lifoFull) |=> (lifoTop == $past(curPri)));

  assert_empty_pop_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (eoiWr && lifoEmpty) |=> (curPri == '0));

  assert_one_access_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ackRd, eoiWr, wrCur, wrSrc}));

endmodule

bind prio_intc prio_intc_chk #(.PRI_W(PRI_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqOut    (irqOut),
  .ackRd     (stb.ackRd),
  .eoiWr     (stb.eoiWr),
  .wrCur     (stb.wrCur),
  .wrSrc     (stb.wrSrc),
  .curPri    (curPri),
  .lifoTop   (lifoTop),
  .vecReg    (vecReg),
  .lifoEmpty (lifoEmpty),
  .lifoFull  (lifoFull)
);

// File: tb/prio_intc_tb.sv
`timescale 1ns/1ps
module prio_intc_tb;

  localparam int NUM_SRC = 8;
  localparam int PRI_W   = 4;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;

  // Fields: {request mask[8], current priority[4], expect irq[4], expect vector[8]}
  localparam int NVEC = 10;
  localparam logic [23:0] VECS [NVEC] = '{
    24'h00_0_0_00,
    24'h01_0_1_00,
    24'h06_0_1_01,
    24'h06_5_0_00,
    24'h06_4_1_01,
    24'hC0_0_1_06,
    24'h08_0_0_00,
    24'h17_E_1_04,
    24'hFF_F_0_00,
    24'h21_2_1_00
  };
  localparam logic [3:0] SRC_PRI [NUM_SRC] = '{4'd3, 4'd5, 4'd5, 4'd0, 4'd15, 4'd1, 4'd7, 4'd7};

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_SRC-1:0] srcReq = '0;
  logic               busWr = 1'b0;
  logic               busRd = 1'b0;
  logic [ADDR_W-1:0]  busAddr = '0;
  logic [PRI_W-1:0]   busWdata = '0;
  logic [DATA_W-1:0]  busRdata;
  logic               irqOut;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  prio_intc #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input int a, input logic [PRI_W-1:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = ADDR_W'(a); busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic regRead(input int a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    busRd = 1'b1; busAddr = ADDR_W'(a);
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [DATA_W-1:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", 32'(irqOut), 0);
    regRead(0, rd); check("R1 cur", rd, 0);
    regRead(1, rd); check("R1 ack", rd, 0);
    for (int i = 0; i < NUM_SRC; i++) begin
      regRead(4 + i, rd); check("R1 srcpri", rd, 0);
    end
    check("R1 irq after ack", 32'(irqOut), 0);
    regWrite(2, 4'h0); // rebalance the stack after the reset-time acknowledge read

    for (int i = 0; i < NUM_SRC; i++) regWrite(4 + i, SRC_PRI[i]);
    // R8: readback and the write-only address
    regRead(8, rd);  check("R8 srcpri4", rd, 15);
    regRead(10, rd); check("R8 srcpri6", rd, 7);
    regRead(2, rd);  check("R8 eoi reads 0", rd, 0);

    // Table walk: R2 R3 R5 R6
    for (int k = 0; k < NVEC; k++) begin
      srcReq = '0;
      regWrite(0, VECS[k][15:12]);
      @(negedge clk);
      srcReq = VECS[k][23:16];
      @(negedge clk);
      check("R2 irq level", 32'(irqOut), 32'(VECS[k][8]));
      if (VECS[k][8]) begin
        regRead(1, rd);
        check("R3 R5 vector", rd, 32'(VECS[k][7:0]) << 2);
        check("R5 irq low", 32'(irqOut), 0);
        regRead(0, rd);
        check("R5 raised cur", rd, 32'(SRC_PRI[VECS[k][2:0]]));
        srcReq = '0;
        regWrite(2, 4'h5);
        regRead(0, rd);
        check("R6 restored cur", rd, 32'(VECS[k][15:12]));
      end
    end

    // R2: registered request, visible one clock later
    srcReq = '0;
    regWrite(0, 4'h0);
    @(negedge clk);
    srcReq = 8'h20;               // line 5, priority 1
    #1 check("R2 not yet", 32'(irqOut), 0);
    @(negedge clk);
    check("R2 one clock", 32'(irqOut), 1);

    // R4: higher line while request high keeps the held vector
    srcReq = 8'h30;               // add line 4, priority 15
    @(negedge clk); @(negedge clk);
    check("R4 irq still", 32'(irqOut), 1);
    regRead(1, rd); check("R4 held vector", rd, 5 << 2);
    check("R5 drop", 32'(irqOut), 0);
    @(negedge clk);
    check("R4 re-raise", 32'(irqOut), 1);
    regRead(1, rd); check("R4 new vector", rd, 4 << 2);
    regRead(0, rd); check("R5 nested cur", rd, 15);

    // R7: pop back to level 1 with line 5 still pending
    srcReq = 8'h20;
    regWrite(2, 4'hA);
    regRead(0, rd); check("R6 pop to 1", rd, 1);
    @(negedge clk);
    check("R7 equal level quiet", 32'(irqOut), 0);
    regWrite(2, 4'h0);
    @(negedge clk);
    check("R7 above restored", 32'(irqOut), 1);
    regRead(1, rd); check("R7 vector", rd, 5 << 2);
    srcReq = '0;
    regWrite(2, 4'h0);

    // R6: pop on an empty stack restores 0
    regWrite(0, 4'h9);
    regRead(0, rd); check("R8 cur write", rd, 9);
    regWrite(2, 4'h3);
    regRead(0, rd); check("R6 empty pop", rd, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule